// File: doc/BRIEF.md
# Host Memory Window and Port Decoder

This block sits between a 16-bit host expansion bus and a set of capture-buffer modules. It makes the buffers appear to the host as a single 64 KB memory segment. The segment lives in the reserved area between 640 KB and 1 MB, and a switch value chooses which segment it is. The block also claims a bank of eight I/O ports at a switch-chosen base. The host reads the window with ordinary block-copy routines. Every read returns a full 16-bit word in the same cycle the strobe is decoded, so the host never needs to insert a wait state.

The window address does not choose which buffer module answers. A select register does that, and the host loads it with an I/O write to port 0. The same register holds a host-write enable. While that enable is clear the window is read-only: memory writes into it are dropped. While it is set, window writes are steered to the selected module, so test data can be injected from the host bus. The block drives the chip selects, the bus transceiver enable and direction, a one-hot strobe and byte offset toward the selected module, and the host read data with its output enable. An access that matches neither the window nor the port bank enables nothing.

Top module: `host_window_dec`

## Requirements
- R1: A memory strobe is a window access only when address bits [19:16] equal `win_seg_sw`; `win_cs` follows in the same cycle. Changing the switch value moves the window.
- R2: A memory read inside the window drives `hdata_oe`=1, `xcvr_en`=1 and `xcvr_dir`=1 (toward the host) in the same cycle. `hdata_out` equals the 16-bit word of the selected module, taken from `mod_rdata[16*k +: 16]` for module k.
- R3: After reset the module select is 0 and the host-write enable is 0.
- R4: An I/O strobe is decoded only when address bits [9:3] equal `io_base_sw`. On a decoded I/O access, `io_cs`=1 and `io_port` carries address bits [2:0]; otherwise `io_port` is 0.
- R5: An I/O write to port 0 loads data bits [1:0] as the module select and data bit 4 as the host-write enable. The new value appears on `mod_sel` after the next clock edge.
- R6: I/O writes to ports 1 to 7 leave the select register unchanged.
- R7: During a window access, `mod_stb` is one-hot on the selected module and `mod_off` carries address bits [15:0]. Outside a window access, both are 0.
- R8: While the host-write enable is 0, a memory write into the window is ignored: `win_cs`, `xcvr_en`, `mod_wr` and `mod_stb` all stay 0.
- R9: While the host-write enable is 1, a memory write into the window asserts `win_cs`, `xcvr_en`, `mod_wr` and the module strobe, with `xcvr_dir`=0. `mod_wdata` equals `hdata_in`.
- R10: An access that matches neither the window nor the port bank drives `xcvr_en`=0, `hdata_oe`=0 and `hdata_out`=0.
- R11: An I/O read of port 0 returns the select in bits [1:0] and the host-write enable in bit 4, with all other bits 0. A read of ports 1 to 7 drives `hdata_oe`=1 with data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| haddr | input | 20 | Host address |
| mem_rd | input | 1 | Memory read strobe, active high |
| mem_wr | input | 1 | Memory write strobe, active high |
| io_rd | input | 1 | I/O read strobe, active high |
| io_wr | input | 1 | I/O write strobe, active high |
| win_seg_sw | input | 4 | Switch value selecting the 64 KB segment |
| io_base_sw | input | 7 | Switch value matched against address bits [9:3] |
| hdata_in | input | 16 | Host write data |
| hdata_out | output | 16 | Host read data |
| hdata_oe | output | 1 | Drive enable for host read data |
| xcvr_en | output | 1 | Bus transceiver enable |
| xcvr_dir | output | 1 | Transceiver direction, 1 toward the host |
| win_cs | output | 1 | Decoded window access |
| io_cs | output | 1 | Decoded port access |
| io_port | output | 3 | Port index within the bank |
| mod_sel | output | 2 | Latched module select |
| mod_stb | output | 4 | One-hot access strobe per buffer module |
| mod_wr | output | 1 | Window write toward the selected module |
| mod_off | output | 16 | Byte offset within the window |
| mod_wdata | output | 16 | Write data toward the modules |
| mod_rdata | input | 64 | Read words of the four modules, module k at [16k+15:16k] |

## Verification
The only state in the block is the select register. If it is corrupted, the fault shows on `mod_sel` right after the faulty edge. On the next window access it also shows as a strobe on the wrong module and as another module's word on `hdata_out`. A wrong host-write enable shows up as soon as a window write is either dropped or let through. A reference model tracks that register and predicts every output in every cycle, so a decode fault is caught in the same cycle as the stimulus that exposes it.

// File: rtl/hwd_pkg.sv
package hwd_pkg;

   typedef struct packed {
      logic win_rd;
      logic win_wr;
      logic io_rd;
      logic io_wr;
   } hwd_dec_t;

   typedef enum logic {
      MATCH_EQ   = 1'b0,
      MATCH_XNOR = 1'b1
   } hwd_match_e;

   typedef enum logic {
      MUX_INDEX = 1'b0,
      MUX_ANDOR = 1'b1
   } hwd_mux_e;

endpackage

// File: rtl/hwd_match.sv
module hwd_match
   import hwd_pkg::*;
#(
   parameter int         W     = 4,
   parameter hwd_match_e STYLE = MATCH_EQ
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         hit
);

   if (W < 1) begin : g_bad_w
      $error("hwd_match: W must be at least 1");
   end

   if (STYLE == MATCH_EQ) begin : g_eq
      assign hit = (a == b);
   end else begin : g_xnor
      logic [W-1:0] same;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign same[i] = ~(a[i] ^ b[i]);
      end
      assign hit = &same;
   end

endmodule

// File: rtl/hwd_decode.sv
module hwd_decode
   import hwd_pkg::*;
#(
   parameter int         SEG_W  = 4,
   parameter int         BASE_W = 7,
   parameter hwd_match_e STYLE  = MATCH_EQ
) (
   input  logic [SEG_W-1:0]  seg_bits,
   input  logic [BASE_W-1:0] base_bits,
   input  logic [SEG_W-1:0]  seg_sw,
   input  logic [BASE_W-1:0] base_sw,
   input  logic              mem_rd,
   input  logic              mem_wr,
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic              host_wr_en,
   output hwd_dec_t          dec
);

   logic seg_hit;
   logic base_hit;

   hwd_match #(.W(SEG_W), .STYLE(STYLE)) seg_m_i (
      .a   (seg_bits),
      .b   (seg_sw),
      .hit (seg_hit)
   );

   hwd_match #(.W(BASE_W), .STYLE(STYLE)) base_m_i (
      .a   (base_bits),
      .b   (base_sw),
      .hit (base_hit)
   );

   always_comb begin
      dec        = '0;
      dec.win_rd = mem_rd & seg_hit;
      dec.win_wr = mem_wr & seg_hit & host_wr_en;
      dec.io_rd  = io_rd & base_hit;
      dec.io_wr  = io_wr & base_hit;
   end

endmodule

// File: rtl/hwd_sel_reg.sv
module hwd_sel_reg #(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [SEL_W-1:0] din_sel,
   input  logic             din_hwen,
   output logic [SEL_W-1:0] sel_q,
   output logic             hwen_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         hwen_q <= 1'b0;
      end else if (load) begin
         sel_q  <= din_sel;
         hwen_q <= din_hwen;
      end
   end

endmodule

// File: rtl/hwd_rdmux.sv
module hwd_rdmux
   import hwd_pkg::*;
#(
   parameter int       DATA_W = 16,
   parameter int       N_MOD  = 4,
   parameter int       SEL_W  = 2,
   parameter hwd_mux_e STYLE  = MUX_INDEX
) (
   input  logic [N_MOD*DATA_W-1:0] words,
   input  logic [SEL_W-1:0]        sel,
   output logic [DATA_W-1:0]       dout
);

   if (STYLE == MUX_INDEX) begin : g_index
      logic [DATA_W-1:0] bank [N_MOD];
      for (genvar i = 0; i < N_MOD; i++) begin : g_unpack
         assign bank[i] = words[i*DATA_W +: DATA_W];
      end
      assign dout = bank[sel];
   end else begin : g_andor
      logic [DATA_W-1:0] term [N_MOD];
      for (genvar i = 0; i < N_MOD; i++) begin : g_term
         assign term[i] = {DATA_W{sel == SEL_W'(i)}} & words[i*DATA_W +: DATA_W];
      end
      always_comb begin
         dout = '0;
         for (int k = 0; k < N_MOD; k++) begin
            dout = dout | term[k];
         end
      end
   end

endmodule

// File: rtl/host_window_dec.sv
module host_window_dec
   import hwd_pkg::*;
#(
   parameter int         ADDR_W    = 20,
   parameter int         WIN_W     = 16,
   parameter int         IO_LSB    = 3,
   parameter int         IO_MSB    = 9,
   parameter int         DATA_W    = 16,
   parameter int         N_MOD     = 4,
   parameter int         SEL_PORT  = 0,
   parameter int         HWEN_BIT  = 4,
   parameter hwd_match_e MATCH_STY = MATCH_EQ,
   parameter hwd_mux_e   MUX_STY   = MUX_INDEX,
   localparam int        SEG_W     = ADDR_W - WIN_W,
   localparam int        BASE_W    = IO_MSB - IO_LSB + 1,
   localparam int        PORT_W    = IO_LSB,
   localparam int        SEL_W     = $clog2(N_MOD)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       haddr,
   input  logic                    mem_rd,
   input  logic                    mem_wr,
   input  logic                    io_rd,
   input  logic                    io_wr,
   input  logic [SEG_W-1:0]        win_seg_sw,
   input  logic [BASE_W-1:0]       io_base_sw,
   input  logic [DATA_W-1:0]       hdata_in,
   output logic [DATA_W-1:0]       hdata_out,
   output logic                    hdata_oe,
   output logic                    xcvr_en,
   output logic                    xcvr_dir,
   output logic                    win_cs,
   output logic                    io_cs,
   output logic [PORT_W-1:0]       io_port,
   output logic [SEL_W-1:0]        mod_sel,
   output logic [N_MOD-1:0]        mod_stb,
   output logic                    mod_wr,
   output logic [WIN_W-1:0]        mod_off,
   output logic [DATA_W-1:0]       mod_wdata,
   input  logic [N_MOD*DATA_W-1:0] mod_rdata
);

   if (SEG_W < 1 || IO_MSB >= WIN_W || IO_LSB < 1 || IO_MSB < IO_LSB) begin : g_bad_addr
      $error("host_window_dec: address split parameters are inconsistent");
   end
   if (N_MOD < 2 || (1 << SEL_W) != N_MOD) begin : g_bad_nmod
      $error("host_window_dec: N_MOD must be a power of two, at least 2");
   end
   if (HWEN_BIT < SEL_W || HWEN_BIT >= DATA_W) begin : g_bad_hwen
      $error("host_window_dec: HWEN_BIT overlaps the select field or exceeds the bus");
   end
   if (SEL_PORT < 0 || SEL_PORT >= (1 << PORT_W)) begin : g_bad_port
      $error("host_window_dec: SEL_PORT outside the port bank");
   end

   hwd_dec_t          dec;
   logic [SEL_W-1:0]  sel_q;
   logic              hwen_q;
   logic              sel_load;
   logic              sel_rd;
   logic [PORT_W-1:0] port_idx;
   logic [DATA_W-1:0] mux_word;
   logic [DATA_W-1:0] rb_word;

   assign port_idx = haddr[PORT_W-1:0];

   hwd_decode #(
      .SEG_W  (SEG_W),
      .BASE_W (BASE_W),
      .STYLE  (MATCH_STY)
   ) decode_i (
      .seg_bits   (haddr[ADDR_W-1:WIN_W]),
      .base_bits  (haddr[IO_MSB:IO_LSB]),
      .seg_sw     (win_seg_sw),
      .base_sw    (io_base_sw),
      .mem_rd     (mem_rd),
      .mem_wr     (mem_wr),
      .io_rd      (io_rd),
      .io_wr      (io_wr),
      .host_wr_en (hwen_q),
      .dec        (dec)
   );

   assign sel_load = dec.io_wr & (port_idx == PORT_W'(SEL_PORT));
   assign sel_rd   = dec.io_rd & (port_idx == PORT_W'(SEL_PORT));

   hwd_sel_reg #(.SEL_W(SEL_W)) sel_reg_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sel_load),
      .din_sel  (hdata_in[SEL_W-1:0]),
      .din_hwen (hdata_in[HWEN_BIT]),
      .sel_q    (sel_q),
      .hwen_q   (hwen_q)
   );

   hwd_rdmux #(
      .DATA_W (DATA_W),
      .N_MOD  (N_MOD),
      .SEL_W  (SEL_W),
      .STYLE  (MUX_STY)
   ) rdmux_i (
      .words (mod_rdata),
      .sel   (sel_q),
      .dout  (mux_word)
   );

   always_comb begin
      rb_word              = '0;
      rb_word[SEL_W-1:0]   = sel_q;
      rb_word[HWEN_BIT]    = hwen_q;
   end

   assign win_cs   = dec.win_rd | dec.win_wr;
   assign io_cs    = dec.io_rd | dec.io_wr;
   assign xcvr_en  = win_cs | io_cs;
   assign xcvr_dir = dec.win_rd | dec.io_rd;
   assign hdata_oe = dec.win_rd | dec.io_rd;
   assign io_port  = io_cs ? port_idx : '0;
   assign mod_sel  = sel_q;
   assign mod_wr   = dec.win_wr;
   assign mod_off  = win_cs ? haddr[WIN_W-1:0] : '0;
   assign mod_wdata = dec.win_wr ? hdata_in : '0;

   always_comb begin
      if (dec.win_rd) begin
         hdata_out = mux_word;
      end else if (sel_rd) begin
         hdata_out = rb_word;
      end else begin
         hdata_out = '0;
      end
   end

   for (genvar i = 0; i < N_MOD; i++) begin : g_stb
      assign mod_stb[i] = win_cs & (sel_q == SEL_W'(i));
   end

endmodule

// File: rtl/hwd_chk.sv
module hwd_chk #(
   parameter int DATA_W   = 16,
   parameter int N_MOD    = 4,
   parameter int SEL_W    = 2,
   parameter int PORT_W   = 3,
   parameter int SEL_PORT = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic              io_wr,
   input logic [DATA_W-1:0] hdata_in,
   input logic              hdata_oe,
   input logic              xcvr_en,
   input logic              xcvr_dir,
   input logic              win_cs,
   input logic              io_cs,
   input logic [PORT_W-1:0] io_port,
   input logic [SEL_W-1:0]  mod_sel,
   input logic [N_MOD-1:0]  mod_stb,
   input logic              mod_wr,
   input logic              hw_en
);

   logic sel_wr;
   assign sel_wr = io_wr & io_cs & (io_port == PORT_W'(SEL_PORT));

   // R7
   stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mod_stb));

   // R7
   stb_needs_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|mod_stb) |-> win_cs);

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(win_cs || io_cs) |-> (!xcvr_en && !hdata_oe));

   // R2
   rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_cs && mem_rd) |-> (hdata_oe && xcvr_en && xcvr_dir));

   // R5
   sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_wr |=> (mod_sel == $past(hdata_in[SEL_W-1:0])));

   // R6
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_wr |=> $stable(mod_sel));

   // R8
   wr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && !hw_en) |-> (!mod_wr && (mod_stb == '0)));

   // R9
   wr_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mod_wr |-> (xcvr_en && !xcvr_dir));

endmodule

bind host_window_dec hwd_chk #(
   .DATA_W   (DATA_W),
   .N_MOD    (N_MOD),
   .SEL_W    (SEL_W),
   .PORT_W   (PORT_W),
   .SEL_PORT (SEL_PORT)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .mem_rd   (mem_rd),
   .mem_wr   (mem_wr),
   .io_wr    (io_wr),
   .hdata_in (hdata_in),
   .hdata_oe (hdata_oe),
   .xcvr_en  (xcvr_en),
   .xcvr_dir (xcvr_dir),
   .win_cs   (win_cs),
   .io_cs    (io_cs),
   .io_port  (io_port),
   .mod_sel  (mod_sel),
   .mod_stb  (mod_stb),
   .mod_wr   (mod_wr),
   .hw_en    (hwen_q)
);

// File: tb/host_window_dec_tb_top.sv
module host_window_dec_tb_top;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] haddr = '0;
   logic        mem_rd = 1'b0, mem_wr = 1'b0, io_rd = 1'b0, io_wr = 1'b0;
   logic [3:0]  win_seg_sw = 4'hD;
   logic [6:0]  io_base_sw = 7'h60;
   logic [15:0] hdata_in = '0;
   logic [15:0] hdata_out;
   logic        hdata_oe, xcvr_en, xcvr_dir, win_cs, io_cs, mod_wr;
   logic [2:0]  io_port;
   logic [1:0]  mod_sel;
   logic [3:0]  mod_stb;
   logic [15:0] mod_off, mod_wdata;
   logic [63:0] mod_rdata = '0;

   int n_tests = 0;
   int n_fail  = 0;
   int m_sel   = 0;
   bit m_hwen  = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   host_window_dec dut_i (
      .clk(clk), .rst_n(rst_n), .haddr(haddr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .io_rd(io_rd), .io_wr(io_wr), .win_seg_sw(win_seg_sw), .io_base_sw(io_base_sw),
      .hdata_in(hdata_in), .hdata_out(hdata_out), .hdata_oe(hdata_oe),
      .xcvr_en(xcvr_en), .xcvr_dir(xcvr_dir), .win_cs(win_cs), .io_cs(io_cs),
      .io_port(io_port), .mod_sel(mod_sel), .mod_stb(mod_stb), .mod_wr(mod_wr),
      .mod_off(mod_off), .mod_wdata(mod_wdata), .mod_rdata(mod_rdata)
   );

   task automatic cmp(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // Reference model: decode and outputs predicted from the requirements.
   task automatic check_all();
      bit win, ioh, e_wrd, e_wwr, e_iord, e_iowr, e_wcs, e_iocs;
      logic [15:0] e_out;
      logic [3:0]  e_stb;
      int port;
      win    = (haddr[19:16] == win_seg_sw);
      ioh    = (haddr[9:3] == io_base_sw);
      port   = int'(haddr[2:0]);
      e_wrd  = mem_rd && win;
      e_wwr  = mem_wr && win && m_hwen;
      e_iord = io_rd && ioh;
      e_iowr = io_wr && ioh;
      e_wcs  = e_wrd || e_wwr;
      e_iocs = e_iord || e_iowr;
      e_out  = 16'h0;
      if (e_wrd) e_out = mod_rdata[16*m_sel +: 16];
      else if (e_iord && port == 0) e_out = 16'(m_sel) | (m_hwen ? 16'h0010 : 16'h0);
      e_stb  = e_wcs ? 4'(1 << m_sel) : 4'h0;
      cmp("R1", "win_cs", 32'(win_cs), 32'(e_wcs));
      cmp("R4", "io_cs", 32'(io_cs), 32'(e_iocs));
      cmp("R4", "io_port", 32'(io_port), e_iocs ? 32'(port) : 32'h0);
      cmp("R2", "hdata_oe", 32'(hdata_oe), 32'(e_wrd || e_iord));
      cmp("R2", "hdata_out", 32'(hdata_out), 32'(e_out));
      cmp("R10", "xcvr_en", 32'(xcvr_en), 32'(e_wcs || e_iocs));
      cmp("R10", "xcvr_dir", 32'(xcvr_dir), 32'(e_wrd || e_iord));
      cmp("R7", "mod_stb", 32'(mod_stb), 32'(e_stb));
      cmp("R7", "mod_off", 32'(mod_off), e_wcs ? 32'(haddr[15:0]) : 32'h0);
      cmp("R8", "mod_wr", 32'(mod_wr), 32'(e_wwr));
      cmp("R9", "mod_wdata", 32'(mod_wdata), e_wwr ? 32'(hdata_in) : 32'h0);
      cmp("R5", "mod_sel", 32'(mod_sel), 32'(m_sel));
   endtask

   task automatic put(input logic [19:0] a, input bit mr, input bit mw,
                      input bit ir, input bit iw, input logic [15:0] d);
      @(negedge clk);
      haddr = a; mem_rd = mr; mem_wr = mw; io_rd = ir; io_wr = iw; hdata_in = d;
      #1;
      check_all();
   endtask

   task automatic tick();
      @(posedge clk);
      if (io_wr && haddr[9:3] == io_base_sw && haddr[2:0] == 3'd0) begin
         m_sel  = int'(hdata_in[1:0]);
         m_hwen = hdata_in[4];
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      mod_rdata = {16'h4444, 16'h3333, 16'h2222, 16'h1111};
      repeat (3) @(negedge clk);
      #1;
      cmp("R3", "mod_sel in reset", 32'(mod_sel), 32'h0);
      rst_n = 1'b1;

      // R3: readback after reset
      put(20'h00300, 0, 0, 1, 0, 16'h0);
      cmp("R3", "port0 readback", 32'(hdata_out), 32'h0);
      tick();

      // R1 / R2: window hit and misses
      put(20'hD1234, 1, 0, 0, 0, 16'h0);
      cmp("R1", "hit D", 32'(win_cs), 32'h1);
      cmp("R2", "word of module 0", 32'(hdata_out), 32'h1111);
      tick();
      put(20'hC1234, 1, 0, 0, 0, 16'h0);
      cmp("R1", "miss C", 32'(win_cs), 32'h0);
      tick();

      // R8: write ignored while host-write disabled
      put(20'hD0002, 0, 1, 0, 0, 16'hBEEF);
      cmp("R8", "write ignored xcvr_en", 32'(xcvr_en), 32'h0);
      tick();

      // R5: select module 2 and enable host write
      put(20'h00300, 0, 0, 0, 1, 16'h0012);
      tick();
      put(20'hD00A0, 1, 0, 0, 0, 16'h0);
      cmp("R5", "word of module 2", 32'(hdata_out), 32'h3333);
      cmp("R7", "strobe module 2", 32'(mod_stb), 32'h4);
      tick();

      // R6: other port write leaves register alone
      put(20'h00303, 0, 0, 0, 1, 16'h0001);
      tick();
      put(20'h00300, 0, 0, 1, 0, 16'h0);
      cmp("R6", "select unchanged", 32'(hdata_out), 32'h0012);
      tick();

      // R9: host write passes
      put(20'hD0010, 0, 1, 0, 0, 16'hCAFE);
      cmp("R9", "mod_wr", 32'(mod_wr), 32'h1);
      cmp("R9", "xcvr_dir", 32'(xcvr_dir), 32'h0);
      tick();

      // R11: other port read; R8 after disabling
      put(20'h00300, 0, 0, 0, 1, 16'h0003);
      tick();
      put(20'h00305, 0, 0, 1, 0, 16'h0);
      cmp("R11", "port5 oe", 32'(hdata_oe), 32'h1);
      cmp("R11", "port5 data", 32'(hdata_out), 32'h0);
      cmp("R4", "port index", 32'(io_port), 32'h5);
      tick();
      put(20'h00300, 0, 0, 1, 0, 16'h0);
      cmp("R11", "port0 data", 32'(hdata_out), 32'h0003);
      tick();
      put(20'hD0010, 0, 1, 0, 0, 16'h1234);
      cmp("R8", "mod_wr disabled", 32'(mod_wr), 32'h0);
      tick();

      // R10 / R4: unmatched accesses
      put(20'h00308, 0, 0, 1, 0, 16'h0);
      cmp("R4", "wrong base", 32'(io_cs), 32'h0);
      cmp("R10", "no oe", 32'(hdata_oe), 32'h0);
      tick();
      put(20'hE0000, 1, 0, 0, 0, 16'h0);
      cmp("R10", "no xcvr", 32'(xcvr_en), 32'h0);
      tick();

      // R1: move the window and the port bank
      win_seg_sw = 4'hE;
      io_base_sw = 7'h62;
      put(20'hE0010, 1, 0, 0, 0, 16'h0);
      cmp("R1", "moved window", 32'(win_cs), 32'h1);
      cmp("R2", "word of module 3", 32'(hdata_out), 32'h4444);
      tick();

      // Random phase against the reference model
      for (int it = 0; it < 4000; it++) begin
         logic [19:0] a;
         int kind;
         logic [15:0] d;
         a    = 20'($urandom);
         kind = int'($urandom_range(0, 5));
         d    = 16'($urandom);
         if ($urandom_range(0, 1) == 1) a[19:16] = win_seg_sw;
         if ($urandom_range(0, 1) == 1) a[9:3] = io_base_sw;
         if ($urandom_range(0, 3) == 0) a[2:0] = 3'd0;
         mod_rdata = {32'($urandom), 32'($urandom)};
         put(a, kind == 1, kind == 2, kind == 3, kind == 4, d);
         tick();
      end

      put(20'h0, 0, 0, 0, 0, 16'h0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule